// File: doc/BRIEF.md
# Audio Zero-Condition Detector

This block watches the two audio channels entering a converter and raises a per-channel zero flag once a channel has stayed silent long enough. It runs in one of two modes. In sample mode each channel delivers parallel words with a one-cycle valid strobe, one strobe per word-clock period, and a channel is silent when its words are all zero. In one-bit stream mode each channel delivers one bit per bit-clock strobe. The bits are gathered into 8-bit groups, and a channel is silent when every group meets the selected idle rule: either a balanced group with as many ones as zeros, or the fixed idle pattern 0x96.

The two flags are also presented together as a 2-bit status word. A mute request combines them: it asks the downstream path to mute when both channels are silent and muting on silence is enabled. The mute request is never raised in one-bit stream mode. The silence window is `PCM_FRAMES` sample periods in sample mode and `STREAM_GROUPS` 8-bit groups in stream mode. The default for stream mode is about 23 ms of a 2.8224 MHz stream.

Top module: `audio_zero_detect`

## Requirements
- R1: After reset, both flags, both status bits and the mute request are 0. All counters and the group bit position start from zero.
- R2: In sample mode (`stream_mode`=0) a channel's flag goes to 1 on the clock edge that accepts its `PCM_FRAMES`-th consecutive valid all-zero word, and not earlier. Each channel counts only its own strobes.
- R3: In sample mode, a valid word on a channel that is not all zero clears that channel's flag and restarts its count at that same edge.
- R4: In sample mode, while `pcm_zero_en`=0 both flags read 0. Counting continues, so flags that have qualified show again once the enable returns to 1.
- R5: `mute_req` is 1 exactly when `stream_mode`=0, `zero_mute_en`=1, and both flags are 1.
- R6: In stream mode `mute_req` stays 0, even when both flags are 1 and `zero_mute_en`=1.
- R7: `zero_status` bit 0 is the left flag and bit 1 is the right flag. A 1 means zero detected.
- R8: In stream mode with `rule_sel`=01, bits are taken on `bit_en` strobes, and the first bit of a group is its MSB. Groups are aligned from reset or from the last time the stream path was inactive. The flag goes to 1 at the edge that completes the `STREAM_GROUPS`-th consecutive group containing exactly four ones.
- R9: In stream mode with `rule_sel`=10, a group counts only if it equals 8'b1001_0110 (0x96). A balanced group of any other value does not count.
- R10: In stream mode, a completed group that fails the active rule clears that channel's flag and reloads its group count to zero.
- R11: In stream mode, `rule_sel`=00 or 11 holds both flags at 0 and clears the stream counters and the group position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stream_mode | input | 1 | 0 = sample mode, 1 = one-bit stream mode |
| pcm_zero_en | input | 1 | Enables the flags in sample mode |
| rule_sel | input | 2 | Stream idle rule: 00 off, 01 balanced, 10 pattern 0x96, 11 off |
| zero_mute_en | input | 1 | Allows the joint-silence mute request |
| smp_l_valid | input | 1 | Left word strobe |
| smp_l_data | input | SAMPLE_W | Left word |
| smp_r_valid | input | 1 | Right word strobe |
| smp_r_data | input | SAMPLE_W | Right word |
| bit_en | input | 1 | Stream bit-clock strobe |
| bit_l | input | 1 | Left stream bit |
| bit_r | input | 1 | Right stream bit |
| zero_l | output | 1 | Left silence flag |
| zero_r | output | 1 | Right silence flag |
| zero_status | output | 2 | {right, left} flags as a status word |
| mute_req | output | 1 | Joint-silence mute request |

## Verification
The bench builds the block with `PCM_FRAMES`=8 and `STREAM_GROUPS`=4, so a complete qualification takes only a few dozen strobes. This brings the exact edge where a flag rises into reach, along with the cycle just before it, restarts after a broken run, and each rule change in stream mode. A channel that stops one word or one group short of the window shows whether the count is off by one in either direction. Mixed inputs check that the channels are independent: a left stream that is balanced but not 0x96 against a right stream that is, and a nonzero word on one channel only.

// File: rtl/azd_pkg.sv
package azd_pkg;
  typedef enum logic [1:0] {
    RULE_OFF   = 2'b00,
    RULE_BAL   = 2'b01,
    RULE_PAT   = 2'b10,
    RULE_OFF_B = 2'b11
  } bs_rule_e;

  localparam logic [7:0] IDLE_PATTERN = 8'h96;
  localparam int unsigned GROUP_BITS  = 8;
endpackage

// File: rtl/azd_rst_sync.sv
module azd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/azd_pcm_chan.sv
module azd_pcm_chan #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned FRAMES   = 1024
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic                valid,
  input  logic [SAMPLE_W-1:0] data,
  output logic                flag
);
  localparam int unsigned CW = $clog2(FRAMES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(FRAMES);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!active) begin
      cnt_d = '0;
    end else if (valid) begin
      if (data == '0) begin
        if (cnt_q != LIMIT) cnt_d = cnt_q + CW'(1);
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign flag = (cnt_q == LIMIT);
endmodule

// File: rtl/azd_stream_chan.sv
module azd_stream_chan
  import azd_pkg::*;
#(
  parameter int unsigned GROUPS = 8114
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  bs_rule_e rule,
  input  logic     bit_en,
  input  logic     bit_in,
  output logic     flag
);
  localparam int unsigned GW = $clog2(GROUPS + 1);
  localparam int unsigned PW = $clog2(GROUP_BITS);
  localparam logic [GW-1:0] LIMIT    = GW'(GROUPS);
  localparam logic [PW-1:0] LAST_POS = PW'(GROUP_BITS - 1);

  logic [GROUP_BITS-2:0] shift_q, shift_d;
  logic [PW-1:0]         pos_q, pos_d;
  logic [GW-1:0]         grp_q, grp_d;
  logic [GROUP_BITS-1:0] group;
  logic                  good;

  always_comb begin
    group = {shift_q, bit_in};
    if (rule == RULE_PAT) good = (group == IDLE_PATTERN);
    else                  good = ($countones(group) == GROUP_BITS / 2);
  end

  always_comb begin
    shift_d = shift_q;
    pos_d   = pos_q;
    grp_d   = grp_q;
    if (!active) begin
      shift_d = '0;
      pos_d   = '0;
      grp_d   = '0;
    end else if (bit_en) begin
      shift_d = group[GROUP_BITS-2:0];
      pos_d   = pos_q + PW'(1);
      if (pos_q == LAST_POS) begin
        if (!good)               grp_d = '0;
        else if (grp_q != LIMIT) grp_d = grp_q + GW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      pos_q   <= '0;
      grp_q   <= '0;
    end else begin
      shift_q <= shift_d;
      pos_q   <= pos_d;
      grp_q   <= grp_d;
    end
  end

  assign flag = (grp_q == LIMIT);
endmodule

// File: rtl/audio_zero_detect.sv
module audio_zero_detect
  import azd_pkg::*;
#(
  parameter int unsigned SAMPLE_W      = 24,
  parameter int unsigned PCM_FRAMES    = 1024,
  parameter int unsigned STREAM_GROUPS = 8114
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                stream_mode,
  input  logic                pcm_zero_en,
  input  logic [1:0]          rule_sel,
  input  logic                zero_mute_en,
  input  logic                smp_l_valid,
  input  logic [SAMPLE_W-1:0] smp_l_data,
  input  logic                smp_r_valid,
  input  logic [SAMPLE_W-1:0] smp_r_data,
  input  logic                bit_en,
  input  logic                bit_l,
  input  logic                bit_r,
  output logic                zero_l,
  output logic                zero_r,
  output logic [1:0]          zero_status,
  output logic                mute_req
);
  localparam int unsigned NCH = 2;

  logic                rst_n_s;
  bs_rule_e            rule;
  logic                pcm_active, stream_active;
  logic [NCH-1:0]      ch_valid, ch_bit, pcm_flag, str_flag, flag;
  logic [SAMPLE_W-1:0] ch_data [NCH];

  azd_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  assign rule          = bs_rule_e'(rule_sel);
  assign pcm_active    = !stream_mode;
  assign stream_active = stream_mode && (rule == RULE_BAL || rule == RULE_PAT);

  assign ch_valid   = {smp_r_valid, smp_l_valid};
  assign ch_bit     = {bit_r, bit_l};
  assign ch_data[0] = smp_l_data;
  assign ch_data[1] = smp_r_data;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    azd_pcm_chan #(.SAMPLE_W(SAMPLE_W), .FRAMES(PCM_FRAMES)) u_pcm (
      .clk(clk), .rst_n(rst_n_s), .active(pcm_active),
      .valid(ch_valid[c]), .data(ch_data[c]), .flag(pcm_flag[c])
    );
    azd_stream_chan #(.GROUPS(STREAM_GROUPS)) u_str (
      .clk(clk), .rst_n(rst_n_s), .active(stream_active), .rule(rule),
      .bit_en(bit_en), .bit_in(ch_bit[c]), .flag(str_flag[c])
    );
    assign flag[c] = stream_mode ? (stream_active && str_flag[c])
                                 : (pcm_zero_en && pcm_flag[c]);
  end

  assign zero_l      = flag[0];
  assign zero_r      = flag[1];
  assign zero_status = flag;
  assign mute_req    = !stream_mode && zero_mute_en && (&flag);
endmodule

// File: rtl/azd_checker.sv
module azd_checker #(
  parameter int unsigned SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stream_mode,
  input logic                pcm_zero_en,
  input logic [1:0]          rule_sel,
  input logic                zero_mute_en,
  input logic                smp_l_valid,
  input logic [SAMPLE_W-1:0] smp_l_data,
  input logic                smp_r_valid,
  input logic [SAMPLE_W-1:0] smp_r_data,
  input logic                zero_l,
  input logic                zero_r,
  input logic [1:0]          zero_status,
  input logic                mute_req
);
  assert_mute_needs_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mute_req |-> (zero_l && zero_r && zero_mute_en));

  assert_no_stream_mute_R6: assert property (@(posedge clk) disable iff (!rst_n)
    stream_mode |-> !mute_req);

  assert_left_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stream_mode && smp_l_valid && smp_l_data != '0) |=> !zero_l);

  assert_right_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!stream_mode && smp_r_valid && smp_r_data != '0) |=> !zero_r);

  assert_pcm_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!stream_mode && !pcm_zero_en) |-> (zero_status == 2'b00));

  assert_rule_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stream_mode && (rule_sel == 2'b00 || rule_sel == 2'b11)) |-> (!zero_l && !zero_r));

  assert_status_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_status[0] == zero_l) && (zero_status[1] == zero_r));
endmodule

bind audio_zero_detect azd_checker #(.SAMPLE_W(SAMPLE_W)) u_azd_checker (
  .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode), .pcm_zero_en(pcm_zero_en),
  .rule_sel(rule_sel), .zero_mute_en(zero_mute_en),
  .smp_l_valid(smp_l_valid), .smp_l_data(smp_l_data),
  .smp_r_valid(smp_r_valid), .smp_r_data(smp_r_data),
  .zero_l(zero_l), .zero_r(zero_r), .zero_status(zero_status), .mute_req(mute_req)
);

// File: tb/audio_zero_detect_test.sv
module audio_zero_detect_test;
  localparam int unsigned SW = 16;
  localparam int unsigned NF = 8;
  localparam int unsigned NG = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          stream_mode, pcm_zero_en, zero_mute_en;
  logic [1:0]    rule_sel;
  logic          smp_l_valid, smp_r_valid;
  logic [SW-1:0] smp_l_data, smp_r_data;
  logic          bit_en, bit_l, bit_r;
  logic          zero_l, zero_r, mute_req;
  logic [1:0]    zero_status;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  audio_zero_detect #(.SAMPLE_W(SW), .PCM_FRAMES(NF), .STREAM_GROUPS(NG)) uut (
    .clk(clk), .rst_n(rst_n), .stream_mode(stream_mode), .pcm_zero_en(pcm_zero_en),
    .rule_sel(rule_sel), .zero_mute_en(zero_mute_en),
    .smp_l_valid(smp_l_valid), .smp_l_data(smp_l_data),
    .smp_r_valid(smp_r_valid), .smp_r_data(smp_r_data),
    .bit_en(bit_en), .bit_l(bit_l), .bit_r(bit_r),
    .zero_l(zero_l), .zero_r(zero_r), .zero_status(zero_status), .mute_req(mute_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_flags(input string req, input logic l, input logic r);
    check({req, " zero_l"}, 32'(zero_l), 32'(l));
    check({req, " zero_r"}, 32'(zero_r), 32'(r));
  endtask

  task automatic frame(input logic lv, input logic [SW-1:0] ld,
                       input logic rv, input logic [SW-1:0] rd);
    @(negedge clk);
    smp_l_valid = lv; smp_l_data = ld;
    smp_r_valid = rv; smp_r_data = rd;
    @(negedge clk);
    smp_l_valid = 1'b0; smp_r_valid = 1'b0;
  endtask

  task automatic group(input logic [7:0] l8, input logic [7:0] r8);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk);
      bit_en = 1'b1; bit_l = l8[i]; bit_r = r8[i];
      @(negedge clk);
      bit_en = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R1 flags", 32'({zero_l, zero_r}), 32'd0);
    check("R1 status", 32'(zero_status), 32'd0);
    check("R1 mute", 32'(mute_req), 32'd0);
  endtask

  task automatic t_pcm_window;
    for (int i = 0; i < NF - 1; i++) frame(1'b1, '0, 1'b1, '0);
    check_flags("R2 one short", 1'b0, 1'b0);
    frame(1'b1, '0, 1'b1, '0);
    check_flags("R2 window reached", 1'b1, 1'b1);
    check("R7 both", 32'(zero_status), 32'd3);
    check("R5 mute disabled", 32'(mute_req), 32'd0);
    @(negedge clk); zero_mute_en = 1'b1;
    @(negedge clk);
    check("R5 mute both", 32'(mute_req), 32'd1);
  endtask

  task automatic t_pcm_clear;
    frame(1'b1, 16'h0001, 1'b0, '0);
    check_flags("R3 left cleared", 1'b0, 1'b1);
    check("R7 right only", 32'(zero_status), 32'd2);
    check("R5 one channel", 32'(mute_req), 32'd0);
    for (int i = 0; i < NF - 1; i++) frame(1'b1, '0, 1'b0, '0);
    check_flags("R3 restart short", 1'b0, 1'b1);
    frame(1'b1, '0, 1'b0, '0);
    check_flags("R3 restart done", 1'b1, 1'b1);
    frame(1'b0, '0, 1'b1, 16'h8000);
    check_flags("R3 right cleared", 1'b1, 1'b0);
    check("R7 left only", 32'(zero_status), 32'd1);
    for (int i = 0; i < NF; i++) frame(1'b0, '0, 1'b1, '0);
    check_flags("R2 right alone", 1'b1, 1'b1);
  endtask

  task automatic t_pcm_enable;
    @(negedge clk); pcm_zero_en = 1'b0;
    @(negedge clk);
    check_flags("R4 gated", 1'b0, 1'b0);
    check("R4 mute gated", 32'(mute_req), 32'd0);
    @(negedge clk); pcm_zero_en = 1'b1;
    @(negedge clk);
    check_flags("R4 restored", 1'b1, 1'b1);
  endtask

  task automatic t_stream_bal;
    @(negedge clk); stream_mode = 1'b1; rule_sel = 2'b01;
    @(negedge clk);
    check_flags("R8 entry", 1'b0, 1'b0);
    for (int i = 0; i < NG - 1; i++) group(8'hF0, 8'h3C);
    check_flags("R8 one short", 1'b0, 1'b0);
    group(8'h5A, 8'h96);
    check_flags("R8 window reached", 1'b1, 1'b1);
    check("R6 no mute", 32'(mute_req), 32'd0);
    group(8'hF8, 8'h3C);
    check_flags("R10 left failed", 1'b0, 1'b1);
    for (int i = 0; i < NG - 1; i++) group(8'h0F, 8'hC3);
    check_flags("R10 reload short", 1'b0, 1'b1);
    group(8'h0F, 8'h00);
    check_flags("R10 reload done", 1'b1, 1'b0);
  endtask

  task automatic t_stream_pat;
    @(negedge clk); rule_sel = 2'b00;
    @(negedge clk);
    check_flags("R11 rule 00", 1'b0, 1'b0);
    @(negedge clk); rule_sel = 2'b10;
    for (int i = 0; i < NG - 1; i++) group(8'h96, 8'hF0);
    check_flags("R9 one short", 1'b0, 1'b0);
    group(8'h96, 8'hF0);
    check_flags("R9 pattern only", 1'b1, 1'b0);
    check("R6 no mute", 32'(mute_req), 32'd0);
    @(negedge clk); rule_sel = 2'b11;
    @(negedge clk);
    check_flags("R11 rule 11", 1'b0, 1'b0);
    @(negedge clk); rule_sel = 2'b10;
    for (int i = 0; i < NG - 1; i++) group(8'h96, 8'h96);
    check_flags("R11 counts cleared", 1'b0, 1'b0);
  endtask

  initial begin
    #200000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    stream_mode = 1'b0; pcm_zero_en = 1'b1; zero_mute_en = 1'b0; rule_sel = 2'b00;
    smp_l_valid = 1'b0; smp_r_valid = 1'b0; smp_l_data = '0; smp_r_data = '0;
    bit_en = 1'b0; bit_l = 1'b0; bit_r = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_pcm_window();
    t_pcm_clear();
    t_pcm_enable();
    t_stream_bal();
    t_stream_pat();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule